// File: doc/BRIEF.md
# Two-Line Flash Instruction Prefetch Buffer

This block sits between a processor's 32-bit instruction fetch port and a slow flash array that returns 64-bit lines with one wait state. It keeps two line entries. A fetch that hits either entry is answered in the same cycle. A fetch that misses stalls until the line comes back from flash, and the requested word is forwarded as the line arrives. When the core reads the last word of a line, the block asks flash for the following line and places it in the other entry. A 32-bit instruction that straddles two lines then completes without a further flash access.

The core can forward a predicted branch target, as a line address, before the branch resolves. A target that is already held costs nothing. A target that misses takes the flash port away from a sequential prefetch that flash has not yet accepted. One cycle after the hint, a registered mispredict flag may arrive. That flag drops the speculative line, or aborts its request, and the fetch port shows only one idle cycle.

Top module: `flash_prefetch_buf`

## Requirements
- R1: A synchronous active-high reset clears both entries and any outstanding flash request, so `fl_req` is low in the first cycle after reset and the first fetch misses.
- R2: A fetch whose line is held returns `f_ready` high in the same cycle. `f_rdata` is the word selected by `f_waddr[0]`: 0 gives line bits 31:0, and 1 gives bits 63:32.
- R3: On a miss, `f_ready` stays low and `fl_line` equals `f_waddr[13:1]`. With an immediate acknowledge, the word is forwarded from `fl_rdata` two cycles after the first request cycle.
- R4: A demand or branch fill replaces the least-recently-used entry. A hit or a fill marks its entry as most recent, and the two valid entries never hold the same line.
- R5: A hit on word 1 of a line, with the next line absent and no flash request outstanding, requests line+1 into the other entry. Word 0 of that line is then served with no stall once the fill has landed, and with one stall cycle if it is fetched at once.
- R6: A hit on word 1 whose next line is already held starts no flash access.
- R7: A branch hint whose line is held starts no flash access.
- R8: A branch hint that misses while a sequential prefetch is waiting for acknowledge withdraws that prefetch and requests the target line instead. Only the target is ever accepted by flash.
- R9: While `br_mispredict` is high, `f_ready` is low. The line requested for the preceding hint is never installed, whether its request was already accepted or is still waiting for acknowledge.
- R10: At most one flash request is outstanding. `fl_line` holds stable while `fl_req` is high and unacknowledged, except when a cancel (R8) or an abort (R9) withdraws it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| f_req | input | 1 | Core fetch request |
| f_waddr | input | 14 | Fetch word address (bit 0 selects the word within the line) |
| f_ready | output | 1 | Fetch data valid this cycle |
| f_rdata | output | 32 | Fetched word |
| br_hint_valid | input | 1 | Early branch target hint |
| br_hint_line | input | 13 | Line address of the predicted target |
| br_mispredict | input | 1 | Registered mispredict flag, one cycle after the hint |
| fl_req | output | 1 | Flash line read request |
| fl_line | output | 13 | Line address of the flash read |
| fl_ack | input | 1 | Flash accepts the request this cycle |
| fl_rvalid | input | 1 | Flash line data valid (the cycle after acknowledge) |
| fl_rdata | input | 64 | Flash line data |

## Verification
A wrong tag, valid bit or LRU pointer shows at the fetch port as a stall count that differs from the expected 0, 1 or 2 cycles. It can also show as a wrong word, within the same fetch or on the next fetch to that line. A speculative line that is wrongly kept shows as a zero-stall fetch where a two-cycle miss was due. A prefetch that is wrongly issued or wrongly suppressed shows in the count of lines that flash has accepted, a few cycles after the triggering fetch or hint. The bench sweeps sequential streams, line crossings, eviction order, and both mispredict timings, and compares every word against data computed arithmetically from the address.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

    localparam int WADDR_W = 14;
    localparam int WORD_W  = 32;
    localparam int WPL     = 2;
    localparam int LINE_W  = WORD_W * WPL;
    localparam int IDX_W   = $clog2(WPL);
    localparam int TAG_W   = WADDR_W - IDX_W;
    localparam int NENT    = 2;

    typedef logic [WADDR_W-1:0] waddr_t;
    typedef logic [TAG_W-1:0]   tag_t;
    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [LINE_W-1:0]  line_t;
    typedef logic [IDX_W-1:0]   slot_t;

    typedef enum logic [1:0] {
        RK_DEMAND   = 2'd0,
        RK_PREFETCH = 2'd1,
        RK_BRANCH   = 2'd2
    } req_kind_e;

    typedef enum logic [1:0] {
        SP_NONE  = 2'd0,
        SP_PEND  = 2'd1,
        SP_QUEUE = 2'd2
    } spec_loc_e;

    typedef struct packed {
        logic      valid;
        logic      acked;
        logic      discard;
        req_kind_e kind;
        tag_t      tag;
        logic      victim;
    } pend_t;

    typedef struct packed {
        logic valid;
        tag_t tag;
    } brq_t;

    typedef struct packed {
        logic  valid;
        tag_t  tag;
        line_t data;
    } entry_t;

    function automatic tag_t line_of(waddr_t a);
        return a[WADDR_W-1:IDX_W];
    endfunction

    function automatic slot_t slot_of(waddr_t a);
        return a[IDX_W-1:0];
    endfunction

    function automatic word_t word_from(line_t l, slot_t s);
        return l[s*WORD_W +: WORD_W];
    endfunction

    function automatic pend_t mk_pend(req_kind_e k, tag_t t, logic v);
        pend_t p;
        p.valid   = 1'b1;
        p.acked   = 1'b0;
        p.discard = 1'b0;
        p.kind    = k;
        p.tag     = t;
        p.victim  = v;
        return p;
    endfunction

endpackage

// File: rtl/pfb_line_store.sv
module pfb_line_store
    import pfb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  tag_t  fetch_tag,
    input  tag_t  hint_tag,
    input  tag_t  next_tag,
    input  tag_t  queue_tag,
    input  logic  fill_en,
    input  logic  fill_idx,
    input  tag_t  fill_tag,
    input  line_t fill_data,
    input  logic  touch_en,
    input  logic  touch_idx,
    output logic  fetch_hit,
    output logic  fetch_idx,
    output line_t fetch_line,
    output logic  hint_hit,
    output logic  next_hit,
    output logic  queue_hit,
    output logic  lru_idx
);

    logic [NENT-1:0] m_fetch, m_hint, m_next, m_queue, v_valid;
    tag_t            v_tag  [NENT];
    line_t           v_data [NENT];

    generate
        for (genvar i = 0; i < NENT; i++) begin : g_ent
            entry_t ent_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    ent_q.valid <= 1'b0;
                end else if (fill_en && fill_idx == 1'(i)) begin
                    ent_q.valid <= 1'b1;
                    ent_q.tag   <= fill_tag;
                    ent_q.data  <= fill_data;
                end
            end

            assign v_valid[i] = ent_q.valid;
            assign v_tag[i]   = ent_q.tag;
            assign v_data[i]  = ent_q.data;
            assign m_fetch[i] = ent_q.valid && ent_q.tag == fetch_tag;
            assign m_hint[i]  = ent_q.valid && ent_q.tag == hint_tag;
            assign m_next[i]  = ent_q.valid && ent_q.tag == next_tag;
            assign m_queue[i] = ent_q.valid && ent_q.tag == queue_tag;
        end
    endgenerate

    always_comb begin
        fetch_line = '0;
        fetch_idx  = 1'b0;
        for (int i = 0; i < NENT; i++) begin
            if (m_fetch[i]) begin
                fetch_line = fetch_line | v_data[i];
                fetch_idx  = 1'(i);
            end
        end
    end

    assign fetch_hit = |m_fetch;
    assign hint_hit  = |m_hint;
    assign next_hit  = |m_next;
    assign queue_hit = |m_queue;

    always_ff @(posedge clk) begin
        if (rst)           lru_idx <= 1'b0;
        else if (fill_en)  lru_idx <= ~fill_idx;
        else if (touch_en) lru_idx <= ~touch_idx;
    end

    // R4
    distinct_tags_chk: assert property (@(posedge clk) disable iff (rst)
        !(v_valid[0] && v_valid[1] && v_tag[0] == v_tag[1]));

endmodule

// File: rtl/pfb_flash_ctrl.sv
module pfb_flash_ctrl
    import pfb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic demand_miss,
    input  tag_t demand_tag,
    input  logic pf_want,
    input  tag_t pf_tag,
    input  logic pf_victim,
    input  logic next_hit,
    input  logic hint_miss,
    input  tag_t hint_tag,
    input  logic queue_hit,
    input  logic mispredict,
    input  logic lru_idx,
    input  logic fl_ack,
    input  logic fl_rvalid,
    output logic fl_req,
    output tag_t fl_line,
    output logic fill_en,
    output logic fill_idx,
    output tag_t fill_tag,
    output logic byp_ok,
    output tag_t byp_tag,
    output tag_t queue_tag
);

    pend_t     pend, pend_n;
    brq_t      brq, brq_n;
    spec_loc_e spec, spec_n;
    logic      idle, done, cancel, abort, brq_live;

    always_comb begin
        pend_n   = pend;
        brq_n    = brq;
        spec_n   = SP_NONE;
        cancel   = 1'b0;
        abort    = 1'b0;
        idle     = !pend.valid;
        done     = pend.valid && pend.acked && fl_rvalid;
        brq_live = brq.valid && !(mispredict && spec == SP_QUEUE);

        if (pend.valid && !pend.acked && fl_ack) pend_n.acked = 1'b1;
        if (done) pend_n.valid = 1'b0;

        if (mispredict) begin
            if (spec == SP_PEND && pend_n.valid && pend_n.kind == RK_BRANCH) begin
                if (pend_n.acked) begin
                    pend_n.discard = 1'b1;
                end else begin
                    pend_n.valid = 1'b0;
                    abort        = 1'b1;
                end
            end
            if (spec == SP_QUEUE) brq_n.valid = 1'b0;
        end

        if (hint_miss) begin
            if (pend.valid && pend.tag == hint_tag) begin
                spec_n = SP_NONE;
            end else if (idle) begin
                pend_n = mk_pend(RK_BRANCH, hint_tag, lru_idx);
                spec_n = SP_PEND;
            end else if (pend.kind == RK_PREFETCH && !pend.acked && !fl_ack) begin
                pend_n = mk_pend(RK_BRANCH, hint_tag, lru_idx);
                cancel = 1'b1;
                spec_n = SP_PEND;
            end else begin
                brq_n.valid = 1'b1;
                brq_n.tag   = hint_tag;
                spec_n      = SP_QUEUE;
            end
        end else if (idle && brq_live) begin
            brq_n.valid = 1'b0;
            if (!queue_hit) pend_n = mk_pend(RK_BRANCH, brq.tag, lru_idx);
        end else if (idle && demand_miss) begin
            pend_n = mk_pend(RK_DEMAND, demand_tag, lru_idx);
        end else if (idle && pf_want && !next_hit) begin
            pend_n = mk_pend(RK_PREFETCH, pf_tag, pf_victim);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend.valid <= 1'b0;
            pend.acked <= 1'b0;
            brq.valid  <= 1'b0;
            spec       <= SP_NONE;
        end else begin
            pend <= pend_n;
            brq  <= brq_n;
            spec <= spec_n;
        end
    end

    assign fl_req    = pend.valid && !pend.acked;
    assign fl_line   = pend.tag;
    assign byp_ok    = done && !pend.discard;
    assign fill_en   = byp_ok;
    assign fill_idx  = pend.victim;
    assign fill_tag  = pend.tag;
    assign byp_tag   = pend.tag;
    assign queue_tag = brq.tag;

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fl_req && !fl_ack && !cancel && !abort) |=> (fl_req && $stable(fl_line)));

endmodule

// File: rtl/flash_prefetch_buf.sv
module flash_prefetch_buf
    import pfb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                f_req,
    input  logic [WADDR_W-1:0]  f_waddr,
    output logic                f_ready,
    output logic [WORD_W-1:0]   f_rdata,
    input  logic                br_hint_valid,
    input  logic [TAG_W-1:0]    br_hint_line,
    input  logic                br_mispredict,
    output logic                fl_req,
    output logic [TAG_W-1:0]    fl_line,
    input  logic                fl_ack,
    input  logic                fl_rvalid,
    input  logic [LINE_W-1:0]   fl_rdata
);

    tag_t  fetch_tag, next_tag, byp_tag, queue_tag, fill_tag;
    slot_t fslot;
    line_t fetch_line;
    logic  fetch_hit, fetch_idx, hint_hit, next_hit, queue_hit, lru_idx;
    logic  fill_en, fill_idx, byp_ok, byp_hit, serve;
    logic  demand_miss, pf_want, hint_miss;

    assign fetch_tag   = line_of(f_waddr);
    assign fslot       = slot_of(f_waddr);
    assign next_tag    = fetch_tag + 1'b1;
    assign byp_hit     = byp_ok && byp_tag == fetch_tag;
    assign serve       = f_req && !br_mispredict && (fetch_hit || byp_hit);
    assign demand_miss = f_req && !br_mispredict && !fetch_hit && !byp_hit;
    assign pf_want     = serve && fetch_hit && fslot == slot_t'(WPL - 1);
    assign hint_miss   = br_hint_valid && !hint_hit;

    assign f_ready = serve;
    assign f_rdata = word_from(fetch_hit ? fetch_line : fl_rdata, fslot);

    pfb_line_store u_store (
        .clk        (clk),
        .rst        (rst),
        .fetch_tag  (fetch_tag),
        .hint_tag   (br_hint_line),
        .next_tag   (next_tag),
        .queue_tag  (queue_tag),
        .fill_en    (fill_en),
        .fill_idx   (fill_idx),
        .fill_tag   (fill_tag),
        .fill_data  (fl_rdata),
        .touch_en   (serve && fetch_hit),
        .touch_idx  (fetch_idx),
        .fetch_hit  (fetch_hit),
        .fetch_idx  (fetch_idx),
        .fetch_line (fetch_line),
        .hint_hit   (hint_hit),
        .next_hit   (next_hit),
        .queue_hit  (queue_hit),
        .lru_idx    (lru_idx)
    );

    pfb_flash_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .demand_miss (demand_miss),
        .demand_tag  (fetch_tag),
        .pf_want     (pf_want),
        .pf_tag      (next_tag),
        .pf_victim   (~fetch_idx),
        .next_hit    (next_hit),
        .hint_miss   (hint_miss),
        .hint_tag    (br_hint_line),
        .queue_hit   (queue_hit),
        .mispredict  (br_mispredict),
        .lru_idx     (lru_idx),
        .fl_ack      (fl_ack),
        .fl_rvalid   (fl_rvalid),
        .fl_req      (fl_req),
        .fl_line     (fl_line),
        .fill_en     (fill_en),
        .fill_idx    (fill_idx),
        .fill_tag    (fill_tag),
        .byp_ok      (byp_ok),
        .byp_tag     (byp_tag),
        .queue_tag   (queue_tag)
    );

    // R9
    mispredict_idle_chk: assert property (@(posedge clk) disable iff (rst)
        br_mispredict |-> !f_ready);

    // R2
    ready_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        f_ready |-> f_req);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !fl_req);

endmodule

// File: tb/test_flash_prefetch_buf.sv
module test_flash_prefetch_buf;
    import pfb_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        f_req = 1'b0;
    logic [13:0] f_waddr = '0;
    logic        f_ready;
    logic [31:0] f_rdata;
    logic        br_hint_valid = 1'b0;
    logic [12:0] br_hint_line = '0;
    logic        br_mispredict = 1'b0;
    logic        fl_req;
    logic [12:0] fl_line;
    logic        fl_ack = 1'b0;
    logic        fl_rvalid = 1'b0;
    logic [63:0] fl_rdata = '0;

    int nchk = 0;
    int nfail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_prefetch_buf i_flash_prefetch_buf (
        .clk(clk), .rst(rst), .f_req(f_req), .f_waddr(f_waddr),
        .f_ready(f_ready), .f_rdata(f_rdata), .br_hint_valid(br_hint_valid),
        .br_hint_line(br_hint_line), .br_mispredict(br_mispredict),
        .fl_req(fl_req), .fl_line(fl_line), .fl_ack(fl_ack),
        .fl_rvalid(fl_rvalid), .fl_rdata(fl_rdata)
    );

    function automatic logic [31:0] word_val(logic [13:0] w);
        logic [15:0] a;
        a = {2'b00, w};
        return {a * 16'd3 + 16'h5A5A, a ^ 16'hF00F};
    endfunction

    function automatic logic [63:0] line_val(logic [12:0] l);
        return {word_val({l, 1'b1}), word_val({l, 1'b0})};
    endfunction

    // flash model: acknowledge after ack_delay waiting cycles, data one cycle later
    int          ack_delay = 0;
    int          wcnt = 0;
    int          acc = 0;
    logic        have_cur = 1'b0;
    logic [12:0] cur = '0;
    logic        rv_pend = 1'b0;
    logic [12:0] rv_line = '0;
    logic [12:0] last_acc = '0;

    always @(negedge clk) begin
        fl_ack    = 1'b0;
        fl_rvalid = 1'b0;
        if (rst) begin
            rv_pend  = 1'b0;
            wcnt     = 0;
            have_cur = 1'b0;
        end else begin
            if (rv_pend) begin
                fl_rvalid = 1'b1;
                fl_rdata  = line_val(rv_line);
                rv_pend   = 1'b0;
            end
            if (fl_req) begin
                if (!have_cur || cur != fl_line) begin
                    have_cur = 1'b1;
                    cur      = fl_line;
                    wcnt     = 0;
                end
                if (wcnt >= ack_delay) begin
                    fl_ack   = 1'b1;
                    rv_pend  = 1'b1;
                    rv_line  = fl_line;
                    last_acc = fl_line;
                    acc++;
                    have_cur = 1'b0;
                end else begin
                    wcnt++;
                end
            end else begin
                have_cur = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; f_req = 1'b0; br_hint_valid = 1'b0; br_mispredict = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_fetch(input int wa, output int stalls, output logic [31:0] data);
        stalls = 0;
        @(negedge clk);
        f_req = 1'b1;
        f_waddr = 14'(wa);
        #1;
        while (!f_ready && stalls < 60) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        data = f_rdata;
    endtask

    task automatic fetch_chk(input string req, input int wa, input int exp_stall);
        int s;
        logic [31:0] d;
        do_fetch(wa, s, d);
        if (exp_stall >= 0) chk(req, $sformatf("stall @%0d", wa), s, exp_stall);
        chk(req, $sformatf("data @%0d", wa), d, word_val(14'(wa)));
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            f_req = 1'b0;
        end
    endtask

    task automatic do_hint(input int line, input bit mis, input bit fetch_then, input int fwa);
        @(negedge clk);
        f_req = 1'b0;
        br_hint_valid = 1'b1;
        br_hint_line = 13'(line);
        @(negedge clk);
        br_hint_valid = 1'b0;
        br_mispredict = mis;
        if (mis && fetch_then) begin
            f_req = 1'b1;
            f_waddr = 14'(fwa);
            #1;
            // R9: the port looks idle during the mispredict cycle
            chk("R9", "f_ready in mispredict cycle", f_ready, 0);
        end
        @(negedge clk);
        br_mispredict = 1'b0;
        f_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        int a0;
        // R1: reset state
        do_reset();
        #1;
        chk("R1", "fl_req after reset", fl_req, 0);
        fetch_chk("R1", 0, 2);
        chk("R3", "miss line address", last_acc, 0);

        // R2 R3 R5: sequential sweep over 16 lines, back to back
        do_reset();
        for (int w = 0; w < 32; w++) begin
            fetch_chk((w % 2) ? "R2" : "R5", w, (w == 0) ? 2 : ((w % 2 == 0) ? 1 : 0));
        end

        // R5: line crossing with the prefetch given time to land
        fetch_chk("R3", 400, -1);
        fetch_chk("R2", 401, 0);
        for (int l = 200; l < 215; l++) begin
            idle(4);
            fetch_chk("R5", 2 * (l + 1), 0);
            fetch_chk("R5", 2 * (l + 1) + 1, 0);
        end

        // R6: next line already held, no flash access
        idle(4);
        a0 = acc;
        fetch_chk("R6", 2 * 215 + 1, 0);
        idle(4);
        chk("R6", "flash accepts", acc, a0);

        // R4: LRU replacement with lines 300, 400, 500
        fetch_chk("R4", 600, -1);
        fetch_chk("R4", 800, 2);
        fetch_chk("R4", 600, 0);
        fetch_chk("R4", 1000, 2);
        fetch_chk("R4", 600, 0);
        fetch_chk("R4", 800, 2);

        // R7: hints to held lines start no access
        idle(3);
        a0 = acc;
        do_hint(300, 0, 0, 0);
        do_hint(400, 0, 0, 0);
        idle(4);
        chk("R7", "flash accepts", acc, a0);

        // R8: hint miss withdraws an unacknowledged prefetch
        ack_delay = 3;
        a0 = acc;
        fetch_chk("R8", 601, 0);
        do_hint(700, 0, 0, 0);
        idle(10);
        chk("R8", "flash accepts", acc, a0 + 1);
        chk("R10", "accepted line", last_acc, 700);
        ack_delay = 0;
        fetch_chk("R8", 1400, 0);

        // R9: mispredict after the speculative line was accepted
        idle(2);
        a0 = acc;
        do_hint(900, 1, 1, 1400);
        idle(4);
        fetch_chk("R9", 1800, 2);
        chk("R9", "flash accepts", acc, a0 + 2);

        // R9 R10: mispredict aborts a request still waiting for acknowledge
        ack_delay = 2;
        idle(2);
        a0 = acc;
        do_hint(950, 1, 0, 0);
        idle(6);
        chk("R10", "aborted request never accepted", acc, a0);
        ack_delay = 0;
        fetch_chk("R9", 1900, 2);
        fetch_chk("R2", 1901, 0);

        idle(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

endmodule